// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is a down-counting interval timer. Software loads a start value through a dedicated write port; the counter then takes one step down on each cycle where the time-base tick enable is high. When the count reaches its end, the block sets an expiry flag in its status register. It raises an interrupt request while that flag is set and the timer is enabled.

Two bits in a control register set how the timer runs. The enable bit lets it count, and clearing it freezes the count where it is. The re-arm bit picks between two modes. In one-shot mode the timer stops after the first expiry. In auto-reload mode it starts the next period from the stored value at the exact tick that ended the previous one, so each period is the same length and no error builds up over time. A stored value of 0 or 1 keeps the timer idle. The expiry flag is cleared by writing a one to its bit.

Top module: `reload_timer`

## Requirements
- R1: After reset the count, the control readback, the status readback and the interrupt request are all zero.
- R2: A write on the reload port stores the value and sets the count to it on the next clock edge. This also restarts a countdown that is already in progress. The reload write wins over a tick in the same cycle.
- R3: While the timer is running and enabled, the count drops by exactly one on each cycle where the tick is high. It does not change on cycles without a tick.
- R4: When the stored value is 0 or 1, the timer never counts and never expires, whatever the tick and control inputs do.
- R5: When control bit 26 (enable) is clear, the count is frozen and no expiry can happen. Setting the bit again resumes the count from the frozen value.
- R6: On the tick that takes the count from 1 to its end, status bit 27 is set. This happens exactly N ticks after a load of value N.
- R7: When control bit 22 (re-arm) is clear, an expiry sets the count to 0 and the timer stays stopped until the next reload write.
- R8: When control bit 22 is set, an expiry sets the count back to the stored value. The next expiry then follows exactly N ticks later, with no tick lost or added.
- R9: The interrupt request is high exactly when status bit 27 is set and control bit 26 is set.
- R10: Writing a 1 to status bit 27 clears it, and writing a 0 to it has no effect. An expiry in the same cycle as a clear leaves the bit set.
- R11: The control readback shows only bits 26 and 22. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Time-base tick enable, one count step per high cycle |
| reload_we_i | input | 1 | Reload value write strobe |
| reload_wdata_i | input | CNT_W | Reload value |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control write data (bit 26 enable, bit 22 re-arm) |
| ctrl_rdata_o | output | 32 | Control register readback |
| stat_we_i | input | 1 | Status write strobe (write-one-to-clear) |
| stat_wdata_i | input | 32 | Status write data (bit 27 clears the expiry flag) |
| stat_rdata_o | output | 32 | Status readback (bit 27 expiry flag) |
| count_o | output | CNT_W | Current count |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong count shows up on `count_o` on the very next clock edge. A wrong run state is slower to show. It appears as an expiry flag that comes one or more ticks early or late, or never comes at all. It can also appear as a count that keeps moving when the stored value is 0 or 1, or when the timer is disabled. The bench sweeps the small reload values in both modes, with both steady and gapped tick patterns. It checks the count and the flag on the tick just before each expiry and on the tick of the expiry itself. An off-by-one error in the period or in the re-arm is therefore caught within a single period.

// File: rtl/reload_timer_pkg.sv
`timescale 1ns/1ps
// Package: register bit positions and control fields shared by the timer.
// Assumes 32-bit control and status registers.
package reload_timer_pkg;
    localparam int REG_W         = 32;
    localparam int CTRL_EN_BIT   = 26;
    localparam int CTRL_REARM_BIT = 22;
    localparam int STS_EXP_BIT   = 27;

    typedef struct packed {
        logic en;
        logic rearm;
    } tmr_ctrl_t;
endpackage

// File: rtl/reload_timer_count.sv
`timescale 1ns/1ps
// Module: down-counter with a stored reload value and a run state.
// Assumes the control fields are already registered. Produces a one-cycle
// expiry pulse on the tick that ends a period.
module reload_timer_count
    import reload_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  tmr_ctrl_t        ctrl_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             run_q;
    logic             step;

    // A step happens only when the timer is armed, enabled and ticked.
    always_comb begin
        step     = run_q && ctrl_i.en && tick_i && !load_i;
        expire_o = step && (cnt_q == ONE);
    end

    // Count, reload storage and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
            run_q    <= 1'b0;
        end else if (load_i) begin
            reload_q <= load_val_i;
            cnt_q    <= load_val_i;
            run_q    <= (load_val_i > ONE);
        end else if (step) begin
            if (cnt_q == ONE) begin
                if (ctrl_i.rearm) begin
                    cnt_q <= reload_q;
                end else begin
                    cnt_q <= '0;
                    run_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign count_o = cnt_q;

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_q)); // R3
    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i.en && !load_i) |=> $stable(cnt_q)); // R5
    AST_SMALL_RELOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q <= ONE) |-> !expire_o); // R4
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !ctrl_i.rearm) |=> (cnt_q == '0)); // R7
    AST_REARM_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && ctrl_i.rearm) |=> (cnt_q == $past(reload_q))); // R8
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i))); // R2
endmodule

// File: rtl/reload_timer_csr.sv
`timescale 1ns/1ps
// Module: control register (enable, re-arm) and status register with the
// write-one-to-clear expiry flag. An expiry wins over a clear in one cycle.
module reload_timer_csr
    import reload_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we_i,
    input  logic [REG_W-1:0] ctrl_wdata_i,
    input  logic             stat_we_i,
    input  logic [REG_W-1:0] stat_wdata_i,
    input  logic             expire_i,
    output tmr_ctrl_t        ctrl_o,
    output logic [REG_W-1:0] ctrl_rdata_o,
    output logic [REG_W-1:0] stat_rdata_o,
    output logic             irq_o
);
    tmr_ctrl_t ctrl_q;
    logic      sts_q;
    logic      unused_wbits;

    // Control register capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we_i) begin
            ctrl_q.en    <= ctrl_wdata_i[CTRL_EN_BIT];
            ctrl_q.rearm <= ctrl_wdata_i[CTRL_REARM_BIT];
        end
    end

    // Expiry flag: set by expiry, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (expire_i) begin
            sts_q <= 1'b1;
        end else if (stat_we_i && stat_wdata_i[STS_EXP_BIT]) begin
            sts_q <= 1'b0;
        end
    end

    // Readback and interrupt request.
    always_comb begin
        ctrl_rdata_o                 = '0;
        ctrl_rdata_o[CTRL_EN_BIT]    = ctrl_q.en;
        ctrl_rdata_o[CTRL_REARM_BIT] = ctrl_q.rearm;
        stat_rdata_o                 = '0;
        stat_rdata_o[STS_EXP_BIT]    = sts_q;
        irq_o                        = sts_q && ctrl_q.en;
    end

    assign ctrl_o       = ctrl_q;
    assign unused_wbits = ^{ctrl_wdata_i, stat_wdata_i};

    AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> sts_q); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we_i && stat_wdata_i[STS_EXP_BIT] && !expire_i) |=> !sts_q); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !(stat_we_i && stat_wdata_i[STS_EXP_BIT])) |=> sts_q); // R10
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_i && !ctrl_wdata_i[CTRL_EN_BIT]) |=> !irq_o); // R9
endmodule

// File: rtl/reload_timer.sv
`timescale 1ns/1ps
// Module: top of the auto-reload interval timer. Joins the counter and the
// register block. Assumes tick_i is a single-cycle enable in the clk domain.
module reload_timer
    import reload_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reload_we_i,
    input  logic [CNT_W-1:0] reload_wdata_i,
    input  logic             ctrl_we_i,
    input  logic [31:0]      ctrl_wdata_i,
    output logic [31:0]      ctrl_rdata_o,
    input  logic             stat_we_i,
    input  logic [31:0]      stat_wdata_i,
    output logic [31:0]      stat_rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    tmr_ctrl_t ctrl;
    logic      expire;

    reload_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (reload_we_i),
        .load_val_i (reload_wdata_i),
        .ctrl_i     (ctrl),
        .count_o    (count_o),
        .expire_o   (expire)
    );

    reload_timer_csr u_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we_i    (ctrl_we_i),
        .ctrl_wdata_i (ctrl_wdata_i),
        .stat_we_i    (stat_we_i),
        .stat_wdata_i (stat_wdata_i),
        .expire_i     (expire),
        .ctrl_o       (ctrl),
        .ctrl_rdata_o (ctrl_rdata_o),
        .stat_rdata_o (stat_rdata_o),
        .irq_o        (irq_o)
    );
endmodule

// File: tb/reload_timer_tb.sv
`timescale 1ns/1ps
module reload_timer_tb;
    localparam int CNT_W = 16;
    localparam logic [31:0] EN_M  = 32'h1 << 26;
    localparam logic [31:0] RA_M  = 32'h1 << 22;
    localparam logic [31:0] EXP_M = 32'h1 << 27;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_i = 1'b0;
    logic             reload_we_i = 1'b0;
    logic [CNT_W-1:0] reload_wdata_i = '0;
    logic             ctrl_we_i = 1'b0;
    logic [31:0]      ctrl_wdata_i = '0;
    logic [31:0]      ctrl_rdata_o;
    logic             stat_we_i = 1'b0;
    logic [31:0]      stat_wdata_i = '0;
    logic [31:0]      stat_rdata_o;
    logic [CNT_W-1:0] count_o;
    logic             irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    reload_timer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .reload_we_i(reload_we_i), .reload_wdata_i(reload_wdata_i),
        .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i), .ctrl_rdata_o(ctrl_rdata_o),
        .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i), .stat_rdata_o(stat_rdata_o),
        .count_o(count_o), .irq_o(irq_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One clock with the given tick; inputs change at negedge only.
    task automatic cyc(input logic t);
        tick_i = t;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        ctrl_we_i = 1'b1; ctrl_wdata_i = v;
        cyc(1'b0);
        ctrl_we_i = 1'b0; ctrl_wdata_i = '0;
    endtask

    task automatic wr_stat(input logic [31:0] v, input logic t);
        stat_we_i = 1'b1; stat_wdata_i = v;
        cyc(t);
        stat_we_i = 1'b0; stat_wdata_i = '0;
    endtask

    task automatic load(input int v);
        reload_we_i = 1'b1; reload_wdata_i = CNT_W'(v);
        cyc(1'b1);
        reload_we_i = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(32'(count_o), 0, "R1 count");
        chk(ctrl_rdata_o, 0, "R1 ctrl");
        chk(stat_rdata_o, 0, "R1 status");
        chk(32'(irq_o), 0, "R1 irq");

        wr_ctrl(32'hFFFF_FFFF);
        chk(ctrl_rdata_o, EN_M | RA_M, "R11 readback");

        // One-shot sweep
        wr_ctrl(EN_M);
        for (int n = 2; n <= 6; n++) begin
            load(n);
            chk(32'(count_o), 32'(n), "R2 load");
            for (int k = 1; k < n; k++) cyc(1'b1);
            chk(32'(count_o), 1, "R3 count to one");
            chk(stat_rdata_o, 0, "R6 not early");
            cyc(1'b1);
            chk(stat_rdata_o, EXP_M, "R6 expiry");
            chk(32'(irq_o), 1, "R9 irq");
            chk(32'(count_o), 0, "R7 one-shot end");
            for (int k = 0; k < 3; k++) cyc(1'b1);
            chk(32'(count_o), 0, "R7 stays stopped");
            wr_stat(32'h0, 1'b0);
            chk(stat_rdata_o, EXP_M, "R10 zero write");
            wr_stat(EXP_M, 1'b0);
            chk(stat_rdata_o, 0, "R10 clear");
            chk(32'(irq_o), 0, "R9 irq clear");
        end

        // Auto-reload sweep with gapped ticks
        wr_ctrl(EN_M | RA_M);
        for (int n = 2; n <= 5; n++) begin
            load(n);
            for (int p = 0; p < 3; p++) begin
                for (int k = 1; k < n; k++) begin cyc(1'b1); cyc(1'b0); end
                chk(stat_rdata_o, 0, "R8 no early expiry");
                cyc(1'b1);
                chk(stat_rdata_o, EXP_M, "R8 periodic expiry");
                chk(32'(count_o), 32'(n), "R8 re-armed value");
                wr_stat(EXP_M, 1'b0);
            end
        end

        // Reload 0 and 1 never run
        for (int v = 0; v <= 1; v++) begin
            load(v);
            for (int k = 0; k < 10; k++) cyc(1'b1);
            chk(32'(count_o), 32'(v), "R4 idle count");
            chk(stat_rdata_o, 0, "R4 no expiry");
        end

        // Restart mid-count
        load(6);
        cyc(1'b1); cyc(1'b1);
        chk(32'(count_o), 4, "R3 counting");
        load(9);
        chk(32'(count_o), 9, "R2 restart");

        // Freeze on disable
        wr_ctrl(EN_M);
        load(5);
        cyc(1'b1); cyc(1'b1);
        chk(32'(count_o), 3, "R3 two ticks");
        wr_ctrl(32'h0);
        for (int k = 0; k < 10; k++) cyc(1'b1);
        chk(32'(count_o), 3, "R5 frozen");
        chk(stat_rdata_o, 0, "R5 no expiry");
        wr_ctrl(EN_M);
        cyc(1'b1); cyc(1'b1);
        chk(32'(count_o), 1, "R5 resumed");
        cyc(1'b1);
        chk(stat_rdata_o, EXP_M, "R6 after resume");

        // Interrupt masking
        wr_ctrl(32'h0);
        chk(32'(irq_o), 0, "R9 masked");
        chk(stat_rdata_o, EXP_M, "R9 flag kept");
        wr_ctrl(EN_M);
        chk(32'(irq_o), 1, "R9 unmasked");

        // Expiry wins over a same-cycle clear
        wr_ctrl(EN_M | RA_M);
        wr_stat(EXP_M, 1'b0);
        load(3);
        cyc(1'b1); cyc(1'b1);
        chk(32'(count_o), 1, "R3 before race");
        wr_stat(EXP_M, 1'b1);
        chk(stat_rdata_o, EXP_M, "R10 expiry wins");
        chk(32'(count_o), 3, "R8 re-arm in race");

        finish_up();
    end
endmodule